// File: doc/BRIEF.md
# Inverting Write-Retry ECC Controller

This controller stands between a host and a memory array in which individual cells may wear out and stay permanently at 0 or at 1. A host write is encoded with a single-error-correcting Hamming code, written to the array, and read back at once. The controller then counts how many codeword cells hold a value other than the one intended. If at most one cell is wrong, the code will repair it on every later read and the write is complete. If two or more are wrong, the controller writes the word a second time in inverted form and records this with a polarity flag. Each cell stuck at the wrong value for the first pattern is then stuck at the right value for the second. If the second attempt also leaves more than one wrong cell, the response reports the block as defective so the host can retire it.

A parameter selects where the polarity flag is kept. In integrated mode the flag is a ninth message bit that the code protects, and the second attempt re-encodes the inverted data together with a set flag. In unintegrated mode the second attempt inverts the entire codeword, check bits included, so no new encoding is needed. The flag is then held outside the codeword as three copies, and a read takes a majority vote of the copies. On a read the controller decodes the word, undoes any inversion, and returns the original data.

Requests enter through a valid/ready handshake. `req_ready` is high only while the controller is idle, so a held `req_valid` is back-pressured for the whole write-verify-retry sequence or read. The response is a plain one-cycle `rsp_done` pulse and cannot be stalled.

Top module: `inv_retry_ecc_ctrl`

## Requirements
- R1: `req_ready` is 1 out of reset and whenever the controller is idle. A request is taken at a clock edge where `req_valid` and `req_ready` are both 1, and `req_ready` is then 0 until the cycle in which `rsp_done` is 1.
- R2: If the read-back of the first write has at most one wrong codeword cell, `rsp_done` is 1 in the cycle after the third rising edge following acceptance, with `rsp_fail`=0 and `rsp_retry`=0.
- R3: If the first read-back has two or more wrong cells, exactly one more write and read-back follow, and `rsp_done` is 1 in the cycle after the sixth edge following acceptance, with `rsp_retry`=1. Every array write is followed in the next cycle by a read-back of that address.
- R4: In integrated mode the first attempt stores the 9-bit message {1'b0, data} and the second stores the encoding of {1'b1, ~data}. Message bit 8 is the polarity flag.
- R5: In unintegrated mode, codeword bits [11:0] of the second attempt are the bitwise inverse of the first attempt's codeword. Word bits [14:12] hold three copies of the polarity: 000 on the first attempt and 111 on the second.
- R6: If the second read-back also has two or more wrong cells, the response has `rsp_fail`=1 and `rsp_retry`=1.
- R7: A read's `rsp_done` is 1 in the cycle after the second edge following acceptance, with both flags 0. In integrated mode the word is decoded first, and the data is inverted if the decoded message bit 8 is 1.
- R8: In unintegrated mode a read takes the majority of bits [14:12]. If the majority is 1 it inverts the codeword bits before decoding, so a single faulty polarity copy does not change the read data.
- R9: Code layout: codeword position p (1-based) is stored in array bit p-1. Check bits sit at positions 1, 2, 4 and 8, and each gives even parity over the positions whose index has that bit set. Message bits fill the other positions in ascending order.
- R10: `rsp_done` lasts one cycle. `req_ready` is 1 in that same cycle, so the next request may be taken at the following edge.
- R11: In unintegrated mode, any two or three stuck cells among codeword bits [11:0] leave the write with `rsp_fail`=0, and a later read returns the written data.
- R12: Only codeword bits enter the wrong-cell count, and a count of 0 or 1 passes. In unintegrated mode a stuck polarity copy alone does not cause a retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Array word address |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_fail | output | 1 | Write left the block defective |
| rsp_retry | output | 1 | Inverted second attempt was used |
| rsp_rdata | output | DATA_W | Corrected read data, valid with a read's done |
| mem_we | output | 1 | Array write strobe |
| mem_re | output | 1 | Array read strobe, data returned next cycle |
| mem_addr | output | ADDR_W | Array address |
| mem_wdata | output | MEM_W | Array write word (13 bits integrated, 15 unintegrated) |
| mem_rdata | input | MEM_W | Array read word, registered by the array |

## Verification
Completion of one request and acceptance of the next can occur in the same cycle: the `rsp_done` pulse coincides with `req_ready` returning high. The bench provokes this by raising `req_valid` for the next request in the very cycle where it sees `rsp_done`. It then judges, against its cycle-by-cycle model, that the request is taken at the next edge and that the earlier response flags are not disturbed. Two controllers, one per polarity placement, receive identical host traffic over arrays with identical stuck-cell masks. Their latencies therefore diverge whenever only one of them needs the retry.

// File: rtl/ecc_inv_pkg.sv
package ecc_inv_pkg;

  // Smallest check-bit count P with 2**P >= K + P + 1 (single-error correction).
  function automatic int hm_check_bits(input int k);
    int res;
    res = 8;
    for (int p = 8; p >= 1; p--) begin
      if ((1 << p) >= k + p + 1) res = p;
    end
    return res;
  endfunction

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WR1,
    ST_RB1,
    ST_CK1,
    ST_WR2,
    ST_RB2,
    ST_CK2,
    ST_RD,
    ST_RDW
  } ctl_state_e;

endpackage

// File: rtl/ecc_hm_encode.sv
module ecc_hm_encode
  import ecc_inv_pkg::*;
#(
  parameter int K = 8,
  localparam int P = hm_check_bits(K),
  localparam int N = K + P
) (
  input  logic [K-1:0] msg,
  output logic [N-1:0] cw
);

  always_comb begin
    logic par;
    int   j;
    cw  = '0;
    j   = 0;
    par = 1'b0;
    // message bits go to positions that are not powers of two
    for (int p = 1; p <= N; p++) begin
      if ((p & (p - 1)) != 0) begin
        cw[p-1] = msg[j];
        j++;
      end
    end
    // check bit i: even parity over positions with bit i of their index set
    for (int i = 0; i < P; i++) begin
      par = 1'b0;
      for (int p = 1; p <= N; p++) begin
        if (((p >> i) & 1) == 1) par = par ^ cw[p-1];
      end
      cw[(1<<i)-1] = par;
    end
  end

endmodule

// File: rtl/ecc_hm_decode.sv
module ecc_hm_decode
  import ecc_inv_pkg::*;
#(
  parameter int K = 8,
  localparam int P = hm_check_bits(K),
  localparam int N = K + P
) (
  input  logic [N-1:0] cw,
  output logic [K-1:0] msg
);

  always_comb begin
    logic [P-1:0] syn;
    logic [N-1:0] fix;
    int           j;
    syn = '0;
    for (int p = 1; p <= N; p++) begin
      if (cw[p-1]) syn = syn ^ P'(p);
    end
    fix = cw;
    if (syn != '0 && int'(syn) <= N) fix[int'(syn)-1] = ~fix[int'(syn)-1];
    msg = '0;
    j   = 0;
    for (int p = 1; p <= N; p++) begin
      if ((p & (p - 1)) != 0) begin
        msg[j] = fix[p-1];
        j++;
      end
    end
  end

endmodule

// File: rtl/ecc_bit_mismatch.sv
module ecc_bit_mismatch #(
  parameter int W = 12,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic [CW-1:0] cnt
);

  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) cnt = cnt + CW'(a[i] ^ b[i]);
  end

endmodule

// File: rtl/inv_retry_ecc_ctrl.sv
module inv_retry_ecc_ctrl
  import ecc_inv_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 4,
  parameter bit INTEGRATED = 1'b1,
  parameter int T_CORR     = 1,
  localparam int MSG_W      = DATA_W + (INTEGRATED ? 1 : 0),
  localparam int PAR_W      = hm_check_bits(MSG_W),
  localparam int CW_W       = MSG_W + PAR_W,
  localparam int POL_COPIES = 3,
  localparam int MEM_W      = CW_W + (INTEGRATED ? 0 : POL_COPIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic              rsp_fail,
  output logic              rsp_retry,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [MEM_W-1:0]  mem_wdata,
  input  logic [MEM_W-1:0]  mem_rdata
);

  localparam int CNT_W = $clog2(CW_W + 1);

  ctl_state_e        state;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              second;
  logic [CW_W-1:0]   img_first;
  logic [CW_W-1:0]   img_second;
  logic [CW_W-1:0]   img_cur;
  logic [MEM_W-1:0]  wr_word;
  logic [DATA_W-1:0] rd_data;
  logic [CNT_W-1:0]  wrong;
  logic              pass;

  assign second  = (state == ST_WR2) || (state == ST_RB2) || (state == ST_CK2);
  assign img_cur = second ? img_second : img_first;

  // polarity placement picks how images are built and how reads are undone
  generate
    if (INTEGRATED) begin : g_integrated
      logic [MSG_W-1:0] msg0, msg1, dmsg;
      assign msg0 = {1'b0, data_q};
      assign msg1 = {1'b1, ~data_q};
      ecc_hm_encode #(.K(MSG_W)) u_enc0 (.msg(msg0), .cw(img_first));
      ecc_hm_encode #(.K(MSG_W)) u_enc1 (.msg(msg1), .cw(img_second));
      assign wr_word = img_cur;
      ecc_hm_decode #(.K(MSG_W)) u_dec (.cw(mem_rdata[CW_W-1:0]), .msg(dmsg));
      assign rd_data = dmsg[DATA_W-1:0] ^ {DATA_W{dmsg[DATA_W]}};
    end else begin : g_separate
      logic [POL_COPIES-1:0] votes;
      logic                  pol;
      logic [CW_W-1:0]       raw;
      ecc_hm_encode #(.K(DATA_W)) u_enc0 (.msg(data_q), .cw(img_first));
      assign img_second = ~img_first;
      assign wr_word    = {{POL_COPIES{second}}, img_cur};
      assign votes      = mem_rdata[MEM_W-1:CW_W];
      assign pol        = ($countones(votes) > (POL_COPIES / 2));
      assign raw        = mem_rdata[CW_W-1:0] ^ {CW_W{pol}};
      ecc_hm_decode #(.K(DATA_W)) u_dec (.cw(raw), .msg(rd_data));
    end
  endgenerate

  ecc_bit_mismatch #(.W(CW_W)) u_cmp (
    .a  (mem_rdata[CW_W-1:0]),
    .b  (img_cur),
    .cnt(wrong)
  );
  assign pass = (wrong <= CNT_W'(T_CORR));

  assign req_ready = (state == ST_IDLE);
  assign mem_we    = (state == ST_WR1) || (state == ST_WR2);
  assign mem_re    = (state == ST_RB1) || (state == ST_RB2) || (state == ST_RD);
  assign mem_addr  = addr_q;
  assign mem_wdata = wr_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      addr_q    <= '0;
      data_q    <= '0;
      rsp_done  <= 1'b0;
      rsp_fail  <= 1'b0;
      rsp_retry <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q <= req_addr;
            data_q <= req_wdata;
            state  <= req_write ? ST_WR1 : ST_RD;
          end
        end
        ST_WR1: state <= ST_RB1;
        ST_RB1: state <= ST_CK1;
        ST_CK1: begin
          if (pass) begin
            rsp_done  <= 1'b1;
            rsp_fail  <= 1'b0;
            rsp_retry <= 1'b0;
            state     <= ST_IDLE;
          end else begin
            state <= ST_WR2;
          end
        end
        ST_WR2: state <= ST_RB2;
        ST_RB2: state <= ST_CK2;
        ST_CK2: begin
          rsp_done  <= 1'b1;
          rsp_fail  <= ~pass;
          rsp_retry <= 1'b1;
          state     <= ST_IDLE;
        end
        ST_RD:  state <= ST_RDW;
        ST_RDW: begin
          rsp_done  <= 1'b1;
          rsp_fail  <= 1'b0;
          rsp_retry <= 1'b0;
          rsp_rdata <= rd_data;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/inv_retry_ecc_chk.sv
module inv_retry_ecc_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_done,
  input logic rsp_fail,
  input logic rsp_retry,
  input logic mem_we,
  input logic mem_re
);

  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  a_r10_done_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready);

  a_r6_fail_implies_retry: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_fail) |-> rsp_retry);

  a_r3_write_then_readback: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (mem_re && !mem_we));

  a_r3_no_strobe_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

endmodule

bind inv_retry_ecc_ctrl inv_retry_ecc_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_done (rsp_done),
  .rsp_fail (rsp_fail),
  .rsp_retry(rsp_retry),
  .mem_we   (mem_we),
  .mem_re   (mem_re)
);

// File: tb/inv_retry_ecc_ctrl_tb_top.sv
module inv_retry_ecc_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       req_valid = 1'b0;
  logic       req_write = 1'b0;
  logic [3:0] req_addr  = '0;
  logic [7:0] req_wdata = '0;

  logic        u_ready, u_done, u_fail, u_retry, u_we, u_re;
  logic [7:0]  u_rdata;
  logic [3:0]  u_addr;
  logic [14:0] u_wdata, u_mrd;
  logic        i_ready, i_done, i_fail, i_retry, i_we, i_re;
  logic [7:0]  i_rdata;
  logic [3:0]  i_addr;
  logic [12:0] i_wdata, i_mrd;

  inv_retry_ecc_ctrl #(.INTEGRATED(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(u_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(u_done), .rsp_fail(u_fail), .rsp_retry(u_retry), .rsp_rdata(u_rdata),
    .mem_we(u_we), .mem_re(u_re), .mem_addr(u_addr), .mem_wdata(u_wdata), .mem_rdata(u_mrd)
  );

  inv_retry_ecc_ctrl #(.INTEGRATED(1'b1)) dut_ip_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(i_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(i_done), .rsp_fail(i_fail), .rsp_retry(i_retry), .rsp_rdata(i_rdata),
    .mem_we(i_we), .mem_re(i_re), .mem_addr(i_addr), .mem_wdata(i_wdata), .mem_rdata(i_mrd)
  );

  // arrays with per-bit stuck-at masks, shared by both controllers
  logic [15:0] sa0 [16];
  logic [15:0] sa1 [16];
  logic [14:0] mem_u [16];
  logic [12:0] mem_i [16];

  always @(posedge clk) begin
    if (u_we) mem_u[u_addr] <= (u_wdata & ~sa0[u_addr][14:0]) | sa1[u_addr][14:0];
    if (u_re) u_mrd <= (mem_u[u_addr] & ~sa0[u_addr][14:0]) | sa1[u_addr][14:0];
    if (i_we) mem_i[i_addr] <= (i_wdata & ~sa0[i_addr][12:0]) | sa1[i_addr][12:0];
    if (i_re) i_mrd <= (mem_i[i_addr] & ~sa0[i_addr][12:0]) | sa1[i_addr][12:0];
  end

  int vectors = 0;
  int fails   = 0;
  logic       ok_u [16];
  logic       ok_i [16];
  logic [7:0] val  [16];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference code: check bits are the XOR of the indices of set message positions
  function automatic logic [15:0] ref_enc(input logic [15:0] msg, input int k);
    logic [15:0] cw;
    logic [3:0]  s;
    int          j;
    cw = '0; s = '0; j = 0;
    for (int pos = 1; pos <= k + 4; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        cw[pos-1] = msg[j];
        if (msg[j]) s = s ^ pos[3:0];
        j++;
      end
    end
    cw[0] = s[0]; cw[1] = s[1]; cw[3] = s[2]; cw[7] = s[3];
    return cw;
  endfunction

  function automatic int ones(input logic [15:0] v);
    int c = 0;
    for (int b = 0; b < 16; b++) c += int'(v[b]);
    return c;
  endfunction

  // expected outcome of a write for one polarity placement (m=1 integrated)
  task automatic model_write(input bit m, input logic [3:0] a, input logic [7:0] d,
                             output int lat, output bit fl, output bit rt,
                             output logic [15:0] img, output bit pol);
    logic [15:0] msk, i1, i2;
    int w1, w2;
    msk = m ? 16'h1FFF : 16'h0FFF;
    i1  = m ? ref_enc({7'b0, 1'b0, d}, 9) : ref_enc({8'b0, d}, 8);
    w1  = ones((((i1 & ~sa0[a]) | sa1[a]) ^ i1) & msk);
    if (w1 <= 1) begin
      lat = 3; fl = 1'b0; rt = 1'b0; img = i1; pol = 1'b0;
    end else begin
      i2  = m ? ref_enc({7'b0, 1'b1, ~d}, 9) : (~i1 & msk);
      w2  = ones((((i2 & ~sa0[a]) | sa1[a]) ^ i2) & msk);
      lat = 6; fl = (w2 > 1); rt = 1'b1; img = i2; pol = 1'b1;
    end
  endtask

  // drives one request at a negedge and compares both controllers every clock
  task automatic issue(input bit wr, input logic [3:0] a, input logic [7:0] d,
                       input int lu, input bit fu, input bit ru,
                       input int li, input bit fi, input bit ri,
                       input bit rd_u, input bit rd_i, input string tag);
    int lmax;
    lmax = (lu > li) ? lu : li;
    check("R1 ready before request (unintegrated)", 32'(u_ready), 32'd1);
    check("R1 ready before request (integrated)", 32'(i_ready), 32'd1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 busy after accept (unintegrated)", 32'(u_ready), 32'd0);
    check("R1 busy after accept (integrated)", 32'(i_ready), 32'd0);
    for (int k = 1; k <= lmax; k++) begin
      @(negedge clk);
      check({tag, " done timing (unintegrated)"}, 32'(u_done), 32'(k == lu));
      check({tag, " done timing (integrated)"}, 32'(i_done), 32'(k == li));
      if (k == lu) begin
        check({tag, " fail flag (unintegrated)"}, 32'(u_fail), 32'(fu));
        check({tag, " retry flag (unintegrated)"}, 32'(u_retry), 32'(ru));
        check("R10 ready with done (unintegrated)", 32'(u_ready), 32'd1);
        if (rd_u) check("R8 read data (unintegrated)", 32'(u_rdata), 32'(d));
      end
      if (k == li) begin
        check({tag, " fail flag (integrated)"}, 32'(i_fail), 32'(fi));
        check({tag, " retry flag (integrated)"}, 32'(i_retry), 32'(ri));
        check("R10 ready with done (integrated)", 32'(i_ready), 32'd1);
        if (rd_i) check("R7 read data (integrated)", 32'(i_rdata), 32'(d));
      end
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d);
    int lu, li;
    bit fu, ru, fi, ri, pu, pi;
    logic [15:0] iu, ii, eu, ei;
    model_write(1'b0, a, d, lu, fu, ru, iu, pu);
    model_write(1'b1, a, d, li, fi, ri, ii, pi);
    issue(1'b1, a, d, lu, fu, ru, li, fi, ri, 1'b0, 1'b0, ru ? "R3" : "R2");
    if (fu) check("R6 defective (unintegrated)", 32'(u_fail), 32'd1);
    if (ones(sa0[a] & 16'h0FFF) + ones(sa1[a] & 16'h0FFF) <= 3)
      check("R11 two or three stuck cells tolerated", 32'(fu), 32'd0);
    eu = (({pu, pu, pu, iu[11:0]} & ~sa0[a][14:0]) | sa1[a][14:0]);
    ei = ((ii[12:0] & ~sa0[a][12:0]) | sa1[a][12:0]);
    check("R5 stored word with polarity copies (unintegrated)", 32'(mem_u[a]), 32'(eu[14:0]));
    check("R4 stored word (integrated) R9", 32'(mem_i[a]), 32'(ei[12:0]));
    ok_u[a] = !fu; ok_i[a] = !fi; val[a] = d;
  endtask

  task automatic do_read(input logic [3:0] a);
    issue(1'b0, a, val[a], 2, 1'b0, 1'b0, 2, 1'b0, 1'b0, ok_u[a], ok_i[a], "R7");
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int a = 0; a < 16; a++) begin
      sa0[a] = '0; sa1[a] = '0; mem_u[a] = '0; mem_i[a] = '0;
      ok_u[a] = 1'b0; ok_i[a] = 1'b0; val[a] = '0;
    end
    repeat (3) @(negedge clk);
    check("R1 reset ready", 32'(u_ready), 32'd1);
    check("R10 reset done low", 32'(u_done | i_done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // clean array
    do_write(4'd0, 8'hA5); do_read(4'd0);
    // one stuck cell
    sa1[1] = 16'h0004;
    do_write(4'd1, 8'h3C); do_read(4'd1);
    // two cells stuck at 1 under an all-zero codeword
    sa1[2] = 16'h0028;
    do_write(4'd2, 8'h00); do_read(4'd2);
    // three stuck cells, mixed polarity
    sa1[3] = 16'h0002; sa0[3] = 16'h0240;
    do_write(4'd3, 8'hFF); do_read(4'd3);
    // defective: two wrong each way
    sa1[5] = 16'h0003; sa0[5] = 16'h0014;
    do_write(4'd5, 8'h00);
    // faulty polarity copy after a retry (R8)
    sa1[6] = 16'h0028; sa0[6] = 16'h4000;
    do_write(4'd6, 8'h00); do_read(4'd6);
    // stuck polarity copy alone causes no retry (R12)
    sa1[7] = 16'h2000;
    do_write(4'd7, 8'h5A);
    check("R12 polarity copy outside count", 32'(u_retry), 32'd0);
    do_read(4'd7);
    // R11 sweep of pairs and triples of stuck cells
    for (int i = 0; i < 12; i++) begin
      logic [3:0] a;
      a = 4'(8 + (i % 8));
      sa0[a] = '0; sa1[a] = '0;
      sa1[a][i] = 1'b1;
      sa0[a][(i + 5) % 12] = 1'b1;
      if (i % 2 == 1) sa1[a][(i + 9) % 12] = 1'b1;
      do_write(a, 8'(i * 37 + 11));
      do_read(a);
    end
    summary();
  end

endmodule